// File: doc/BRIEF.md
# Low-Power Wake Pin Controller

This block runs one bidirectional open-drain wake pin on a sensing device that switches between a Normal mode and a Low-power mode. In Normal mode it keeps the pin pulled low. In Low-power mode it releases the pin so that an external or internal pull-up can take it high. While released, the pin acts as a wake input. A falling edge on the pin, or any internal wake event, ends Low-power mode.

The raw pad level goes through a synchronizer chain. A falling edge counts only when the previously sampled level was high. A pin edge is honoured only when the I/O supply is good, or when a stored supply-check override bit is set. An internal event is honoured whatever the supply state. The first valid wake in a Low-power stay does three things: it emits a one-cycle request to the mode controller, records which source caused it, and pulls the pin low again. The pin stays low until the mode controller returns to Normal mode.

Top module: `wake_pin_ctrl`

## Requirements
- R1: After reset the pull-down enable is 1, the wake request is 0, the wake source reads 0 (none), and the supply-check override bit is 0.
- R2: While `lp_mode_i` is 0 the pull-down enable is 1 whatever the supply state is, and no pin edge or internal event produces a wake request.
- R3: In Low-power mode, until a wake occurs, the pull-down enable is 0.
- R4: In Low-power mode with the supply good, a pad fall from a sampled high raises `wake_req_o` for one cycle. The pulse is seen after the third rising clock edge that follows the pad change, and `wake_src_o` reads 1 (pin).
- R5: In Low-power mode with the supply low and the override bit 0, a pad falling edge produces no request and leaves the pin released.
- R6: With the override bit 1, a pad falling edge in Low-power mode wakes the device even while the supply is low.
- R7: Any bit of `evt_req_i` set in Low-power mode gives a request after the next rising edge, with `wake_src_o` = 2 (internal). The supply state has no effect on this.
- R8: From the cycle of the wake request until `lp_mode_i` returns to 0 the pull-down enable is 1. Only one request is made per Low-power stay, even if an event stays asserted.
- R9: A pad that is low throughout a Low-power stay, and never sampled high, produces no request.
- R10: When a pin edge and an internal event qualify in the same cycle, the source reported is the pin (1).
- R11: A cycle with `cfg_we_i` = 1 loads `cfg_wdata_i` into the override bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode_i | input | 1 | 1 = Low-power mode, 0 = Normal mode |
| pad_i | input | 1 | Raw pad input level |
| vio_good_i | input | 1 | I/O supply present |
| cfg_we_i | input | 1 | Write strobe for the override bit |
| cfg_wdata_i | input | 1 | Override bit value to load |
| evt_req_i | input | N_EVT | Internal wake-event requests |
| pad_pd_en_o | output | 1 | Open-drain pull-down enable |
| wake_req_o | output | 1 | One-cycle wake request to the mode controller |
| wake_src_o | output | 2 | Last wake source: 0 none, 1 pin, 2 internal |

## Verification
The pin path is tried with a supply-good edge and a supply-low edge, the latter once with the override clear and once with it set. Together these separate the three gating outcomes. A pad that stays low from the start of a Low-power stay shows that edges require a sampled high. Internal events are applied with the supply down, held for several cycles, and made to coincide with a pin edge. These cases distinguish supply independence, single-shot behaviour and source priority. Normal-mode stimulus with pad toggles and events shows that the pin stays driven and that no request is made.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_PIN  = 2'd1,
    WSRC_INT  = 2'd2
  } wsrc_e;

  // A pin edge counts in low power when supply is good or override is set.
  function automatic logic pin_wake_ok(input logic lp, input logic fall,
                                       input logic vio, input logic chk);
    return lp & fall & (vio | chk);
  endfunction

  // Pin wins when both qualify in the same cycle.
  function automatic wsrc_e pick_src(input logic pin_ok, input logic int_ok);
    if (pin_ok)      return WSRC_PIN;
    else if (int_ok) return WSRC_INT;
    else             return WSRC_NONE;
  endfunction

endpackage

// File: rtl/wpc_edge_sync.sv
module wpc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pad_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign level_o = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_o;
  end

  // An edge exists only when the previous sample was high.
  assign fall_o = prev_q & ~level_o;

endmodule

// File: rtl/wpc_wake_qual.sv
module wpc_wake_qual
  import wpc_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_mode_i,
  input  logic             fall_i,
  input  logic             vio_good_i,
  input  logic             chk_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic             woke_o,
  output logic             req_o,
  output wsrc_e            src_o
);

  logic  pin_ok, int_ok, fire;
  logic  woke_q, req_q;
  wsrc_e src_q;

  assign pin_ok = pin_wake_ok(lp_mode_i, fall_i, vio_good_i, chk_i);
  assign int_ok = lp_mode_i & (|evt_i);
  assign fire   = (pin_ok | int_ok) & ~woke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      woke_q <= 1'b0;
      req_q  <= 1'b0;
      src_q  <= WSRC_NONE;
    end else begin
      req_q <= fire;
      if (!lp_mode_i)  woke_q <= 1'b0;
      else if (fire)   woke_q <= 1'b1;
      if (fire) src_q <= pick_src(pin_ok, int_ok);
    end
  end

  assign woke_o = woke_q;
  assign req_o  = req_q;
  assign src_o  = src_q;

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  p_lp_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(lp_mode_i));

  p_supply_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && src_q == WSRC_PIN) |-> $past(vio_good_i || chk_i));

  p_src_named_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (src_q != WSRC_NONE));

endmodule

// File: rtl/wpc_pad_drive.sv
module wpc_pad_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_mode_i,
  input  logic woke_i,
  input  logic req_i,
  output logic pd_en_o
);

  // Pulled low in Normal mode, and again once a wake has been taken.
  assign pd_en_o = ~lp_mode_i | woke_i;

  p_normal_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode_i |-> pd_en_o);

  p_drive_after_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> pd_en_o);

endmodule

// File: rtl/wake_pin_ctrl.sv
module wake_pin_ctrl
  import wpc_pkg::*;
#(
  parameter int N_EVT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_mode_i,
  input  logic             pad_i,
  input  logic             vio_good_i,
  input  logic             cfg_we_i,
  input  logic             cfg_wdata_i,
  input  logic [N_EVT-1:0] evt_req_i,
  output logic             pad_pd_en_o,
  output logic             wake_req_o,
  output logic [1:0]       wake_src_o
);

  logic  chk_q;
  logic  pad_level, pad_fall;
  logic  woke;
  wsrc_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_q <= 1'b0;
    else if (cfg_we_i) chk_q <= cfg_wdata_i;
  end

  wpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_i   (pad_i),
    .level_o (pad_level),
    .fall_o  (pad_fall)
  );

  wpc_wake_qual #(.N_EVT(N_EVT)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_mode_i  (lp_mode_i),
    .fall_i     (pad_fall),
    .vio_good_i (vio_good_i),
    .chk_i      (chk_q),
    .evt_i      (evt_req_i),
    .woke_o     (woke),
    .req_o      (wake_req_o),
    .src_o      (src)
  );

  wpc_pad_drive u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_mode_i (lp_mode_i),
    .woke_i    (woke),
    .req_i     (wake_req_o),
    .pd_en_o   (pad_pd_en_o)
  );

  assign wake_src_o = src;

  logic unused_level;
  assign unused_level = pad_level;

endmodule

// File: tb/wake_pin_ctrl_tb.sv
`timescale 1ns/1ps
module wake_pin_ctrl_tb;

  localparam int N_EVT = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lp_mode = 1'b0;
  logic             ext_pad = 1'b1;
  logic             vio_good = 1'b1;
  logic             cfg_we = 1'b0;
  logic             cfg_wdata = 1'b0;
  logic [N_EVT-1:0] evt = '0;
  logic             pd_en, wake_req;
  logic [1:0]       wake_src;
  logic             pad;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Open-drain pad: low whenever the block pulls down.
  assign pad = pd_en ? 1'b0 : ext_pad;

  wake_pin_ctrl #(.N_EVT(N_EVT), .SYNC_STAGES(2)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_mode_i   (lp_mode),
    .pad_i       (pad),
    .vio_good_i  (vio_good),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .evt_req_i   (evt),
    .pad_pd_en_o (pd_en),
    .wake_req_o  (wake_req),
    .wake_src_o  (wake_src)
  );

  always @(posedge clk) if (rst_n && wake_req) pulses++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic go_normal();
    lp_mode = 1'b0; evt = '0; ext_pad = 1'b1; vio_good = 1'b1;
    tick(3);
  endtask

  task automatic go_lp();
    ext_pad = 1'b1; lp_mode = 1'b1;
    tick(5);
  endtask

  task automatic write_chk(input logic v);
    cfg_we = 1'b1; cfg_wdata = v; tick(1); cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check(pd_en, 1, "R1 pull-down after reset");
    check(wake_req, 0, "R1 request after reset");
    check(wake_src, 0, "R1 source after reset");
  endtask

  task automatic t_normal();
    int p0 = pulses;
    vio_good = 1'b0; tick(1);
    check(pd_en, 1, "R2 pull-down with supply low");
    ext_pad = 1'b0; evt = 4'b0101; tick(3);
    ext_pad = 1'b1; tick(3); ext_pad = 1'b0; tick(4);
    check(pulses - p0, 0, "R2 no wake in Normal mode");
    check(pd_en, 1, "R2 pull-down held");
    go_normal();
  endtask

  task automatic t_supply_ignore();
    int p0;
    go_lp();
    check(pd_en, 0, "R3 released in Low-power mode");
    p0 = pulses;
    vio_good = 1'b0; ext_pad = 1'b0; tick(6);
    check(pulses - p0, 0, "R5 edge ignored, reset override 0 (R1)");
    check(pd_en, 0, "R5 pin stays released");
    ext_pad = 1'b1; vio_good = 1'b1; tick(4);
    check(pulses - p0, 0, "R5 no late wake after supply returns");
    go_normal();
  endtask

  task automatic t_pin_wake();
    int p0;
    go_lp();
    p0 = pulses;
    ext_pad = 1'b0; tick(2);
    check(wake_req, 0, "R4 no request before third edge");
    tick(1);
    check(wake_req, 1, "R4 request on third edge");
    check(wake_src, 1, "R4 source pin");
    check(pd_en, 1, "R8 pull-down on wake");
    ext_pad = 1'b1; tick(1);
    check(wake_req, 0, "R4 single-cycle pulse");
    tick(4);
    check(pd_en, 1, "R8 pull-down held after wake");
    check(pulses - p0, 1, "R4 exactly one pulse");
    go_normal();
  endtask

  task automatic t_override();
    int p0;
    write_chk(1'b1);
    go_lp();
    p0 = pulses;
    vio_good = 1'b0; ext_pad = 1'b0; tick(3);
    check(wake_req, 1, "R6 override wakes with supply low (R11)");
    check(wake_src, 1, "R6 source pin");
    tick(2);
    check(pulses - p0, 1, "R6 one pulse");
    go_normal();
    write_chk(1'b0);
  endtask

  task automatic t_internal();
    int p0;
    go_lp();
    p0 = pulses;
    vio_good = 1'b0; evt = 4'b1000; tick(1);
    check(wake_req, 1, "R7 internal wake next edge");
    check(wake_src, 2, "R7 source internal");
    check(pd_en, 1, "R8 pull-down on internal wake");
    tick(6);
    check(pulses - p0, 1, "R8 held event gives one pulse");
    check(pd_en, 1, "R8 pull-down held with supply low");
    go_normal();
  endtask

  task automatic t_no_high();
    int p0 = pulses;
    ext_pad = 1'b0; lp_mode = 1'b1; tick(8);
    check(pulses - p0, 0, "R9 no wake without sampled high");
    check(pd_en, 0, "R9 pin released");
    go_normal();
  endtask

  task automatic t_both();
    go_lp();
    ext_pad = 1'b0; tick(2);
    evt = 4'b0001; tick(1);
    check(wake_req, 1, "R10 request on coincidence");
    check(wake_src, 1, "R10 pin has priority");
    go_normal();
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_normal();
    t_supply_ignore();
    t_pin_wake();
    t_override();
    t_internal();
    t_no_high();
    t_both();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule